// File: doc/BRIEF.md
# Octal Low-Side Channel Protection and Diagnostics

This block sits between the output command latch and the power stages of an eight-channel low-side switch. It gates each channel's drive enable and builds an 8-bit status vector for the serial interface. Two protection classes share the block. The first `N_LIM` channels are current-limited loads, such as lamps with inrush current. They are switched off and latched off only when their overtemperature flag asserts. The remaining channels switch off in the same cycle that their overcurrent flag asserts, and they stay latched off. A latched channel is released when a new command-latch update turns it off. After that it can be switched on again.

For the current-limited channels the diagnostic condition is filtered. There are two conditions. In the first, the channel is commanded on while its output is above the diagnostic threshold. In the second, the channel is commanded off while its output is below the threshold. Either condition must persist for `FILT_CYC` clock cycles before it sets a fault latch, and the fault latch is held clear while `cs_n_i` is low. The other channels report their status live, with no filter. The status vector is captured into `status_o` when chip select falls. A fault that arises during a read, or that goes away, therefore shows up only on a later read.

Top module: `lsd_guard`

## Requirements
- R1: While rst_ni is low, drv_en_o and status_o are all zero. After reset is released, drv_en_o stays zero until the first rising clock edge, and after that edge it follows the commands.
- R2: With no trip flag and no latched overload, drv_en_o[k] equals cmd_on_i[k], combinationally.
- R3: Channels at bit positions N_LIM..N_CH-1 (bits 2..7 by default) are the trip class, and ovc_i[j] belongs to channel bit j+N_LIM. If ovc_i[j] is high while the channel is commanded on, drv_en_o drops in that same cycle and the overload latch is set. The drive then stays off after ovc_i[j] falls.
- R4: Channels at bit positions 0..N_LIM-1 are the limit class. For these, ovt_i[k] behaves as ovc_i does in R3: it switches the drive off at once and latches it off.
- R5: When latch_upd_i is high in a cycle where cmd_on_i[k] is 0, the channel's overload latch clears. When latch_upd_i is high while cmd_on_i[k] is 1, the latch holds.
- R6: Live status of a trip-class bit: 1 when its overload latch is set, otherwise cmd_on_i[k] XOR above_thr_i[k]. Bit = 1 means no fault.
- R7: A limit-class fault condition is (cmd_on_i[k] AND above_thr_i[k]) OR (NOT cmd_on_i[k] AND NOT above_thr_i[k]). If it is sampled high on FILT_CYC consecutive clock edges while cs_n_i is high, the fault latch is set and the status bit reads 0. If it is sampled high on only FILT_CYC-1 edges, the latch is not set.
- R8: The filter count restarts whenever the condition is sampled low, so two runs of FILT_CYC-1 cycles with a gap between them do not set the fault latch.
- R9: status_o loads the live status on the clock edge where cs_n_i is first sampled low, and it holds at every other edge. The read clears the limit-class fault latches. A persistent fault reads 0 on each read, and a fault that has gone away reads 1 on the next read.
- R10: The limit-class fault latches stay clear while cs_n_i is low. A condition that exists only while cs_n_i is low is never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_on_i | input | N_CH | Commanded on state per channel, from the command latch |
| latch_upd_i | input | 1 | One-cycle strobe that comes with a new cmd_on_i value |
| above_thr_i | input | N_CH | Output voltage above diagnostic threshold, per channel |
| ovc_i | input | N_CH-N_LIM | Overcurrent flags of the trip-class channels |
| ovt_i | input | N_LIM | Overtemperature flags of the limit-class channels |
| cs_n_i | input | 1 | Serial chip select, active low, synchronous to clk_i |
| drv_en_o | output | N_CH | Gated drive enable per channel |
| status_o | output | N_CH | Status vector captured at chip-select fall, 1 = no fault |

## Verification
The bench keeps the default eight channels with two in the limit class, so both protection classes and the bit mapping of ovc_i are exercised. It sets FILT_CYC to 8, which puts the FILT_CYC-1 and FILT_CYC boundaries and the count restart within a few cycles of each other. With this setting the bench drives condition windows around those boundaries, around chip-select windows and around pairs of back-to-back reads.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  // 30 us at a 20 MHz system clock
  localparam int unsigned FILT_CYC_DEF = 600;
  localparam int unsigned N_CH_DEF     = 8;
  localparam int unsigned N_LIM_DEF    = 2;
endpackage

// File: rtl/lsd_filter.sv
module lsd_filter #(
  parameter int unsigned FILT_CYC = lsd_pkg::FILT_CYC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  input  logic clr_i,
  output logic fault_o
);
  localparam int unsigned CNT_W = (FILT_CYC > 2) ? $clog2(FILT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             fault_q;
  logic             full;

  assign full = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!cond_i) begin
      cnt_q <= '0;
    end else if (!full) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // clear while selected wins over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
    end else if (clr_i) begin
      fault_q <= 1'b0;
    end else if (cond_i && full) begin
      fault_q <= 1'b1;
    end
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/lsd_ovl.sv
module lsd_ovl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic cmd_i,
  input  logic upd_i,
  input  logic trip_i,
  output logic ol_o,
  output logic drv_o
);
  logic ol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ol_q <= 1'b0;
    end else if (upd_i && !cmd_i) begin
      ol_q <= 1'b0;
    end else if (cmd_i && trip_i) begin
      ol_q <= 1'b1;
    end
  end

  // trip gates the drive in the same cycle, the latch keeps it off
  assign drv_o = run_i & cmd_i & ~ol_q & ~trip_i;
  assign ol_o  = ol_q;
endmodule

// File: rtl/lsd_snap.sv
module lsd_snap #(
  parameter int unsigned W = lsd_pkg::N_CH_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_n_i,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] snap_o
);
  logic         cs_q;
  logic [W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      snap_q <= '0;
    end else begin
      cs_q <= cs_n_i;
      if (cs_q && !cs_n_i) snap_q <= live_i;
    end
  end

  assign snap_o = snap_q;
endmodule

// File: rtl/lsd_guard.sv
module lsd_guard #(
  parameter int unsigned N_CH     = lsd_pkg::N_CH_DEF,
  parameter int unsigned N_LIM    = lsd_pkg::N_LIM_DEF,
  parameter int unsigned FILT_CYC = lsd_pkg::FILT_CYC_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_CH-1:0]      cmd_on_i,
  input  logic                 latch_upd_i,
  input  logic [N_CH-1:0]      above_thr_i,
  input  logic [N_CH-N_LIM-1:0] ovc_i,
  input  logic [N_LIM-1:0]     ovt_i,
  input  logic                 cs_n_i,
  output logic [N_CH-1:0]      drv_en_o,
  output logic [N_CH-1:0]      status_o
);
  logic             run_q;
  logic [N_CH-1:0]  live;
  logic [N_CH-1:0]  ol_w;
  logic [N_LIM-1:0] fault_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic trip;
    if (k < N_LIM) begin : g_lim
      assign trip = ovt_i[k];
      lsd_filter #(.FILT_CYC(FILT_CYC)) u_flt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cond_i  (~(cmd_on_i[k] ^ above_thr_i[k])),
        .clr_i   (~cs_n_i),
        .fault_o (fault_w[k])
      );
      assign live[k] = ~fault_w[k];
    end else begin : g_trp
      assign trip    = ovc_i[k-N_LIM];
      assign live[k] = ol_w[k] | (cmd_on_i[k] ^ above_thr_i[k]);
    end
    lsd_ovl u_ovl (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_q),
      .cmd_i  (cmd_on_i[k]),
      .upd_i  (latch_upd_i),
      .trip_i (trip),
      .ol_o   (ol_w[k]),
      .drv_o  (drv_en_o[k])
    );
  end

  lsd_snap #(.W(N_CH)) u_snap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_n_i (cs_n_i),
    .live_i (live),
    .snap_o (status_o)
  );
endmodule

// File: rtl/lsd_guard_chk.sv
module lsd_guard_chk #(
  parameter int unsigned N_CH  = lsd_pkg::N_CH_DEF,
  parameter int unsigned N_LIM = lsd_pkg::N_LIM_DEF
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [N_CH-1:0]       cmd_on_i,
  input logic [N_CH-N_LIM-1:0] ovc_i,
  input logic [N_LIM-1:0]      ovt_i,
  input logic                  cs_n_i,
  input logic [N_CH-1:0]       drv_en_o,
  input logic [N_CH-1:0]       status_o,
  input logic [N_CH-1:0]       ol_w,
  input logic [N_LIM-1:0]      fault_w
);
  for (genvar k = 0; k < N_CH; k++) begin : g_a
    // R2
    drv_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(drv_en_o[k]) |-> cmd_on_i[k]);
    // R3 R4
    latched_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ol_w[k] |-> !drv_en_o[k]);
    if (k < N_LIM) begin : g_l
      // R4
      ovt_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_on_i[k] && ovt_i[k]) |-> !drv_en_o[k]);
      // R4
      ovt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_on_i[k] && ovt_i[k]) |=> !drv_en_o[k]);
    end else begin : g_t
      // R3
      ovc_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_on_i[k] && ovc_i[k-N_LIM]) |-> !drv_en_o[k]);
      // R3
      ovc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_on_i[k] && ovc_i[k-N_LIM]) |=> !drv_en_o[k]);
    end
  end

  // R9
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> $stable(status_o));
  // R10
  sel_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_i |=> (fault_w == '0));
endmodule

bind lsd_guard lsd_guard_chk #(.N_CH(N_CH), .N_LIM(N_LIM)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cmd_on_i (cmd_on_i),
  .ovc_i    (ovc_i),
  .ovt_i    (ovt_i),
  .cs_n_i   (cs_n_i),
  .drv_en_o (drv_en_o),
  .status_o (status_o),
  .ol_w     (ol_w),
  .fault_w  (fault_w)
);

// File: tb/sim_lsd_guard.sv
module sim_lsd_guard;
  localparam int CLK_P = 10;
  localparam int F     = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cmd = '0;
  logic       upd = 1'b0;
  logic [7:0] above = '0;
  logic [5:0] ovc = '0;
  logic [1:0] ovt = '0;
  logic       cs_n = 1'b1;
  logic [7:0] drv;
  logic [7:0] stat;
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  lsd_guard #(.N_CH(8), .N_LIM(2), .FILT_CYC(F)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_on_i(cmd), .latch_upd_i(upd),
    .above_thr_i(above), .ovc_i(ovc), .ovt_i(ovt), .cs_n_i(cs_n),
    .drv_en_o(drv), .status_o(stat)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(output logic [7:0] s);
    cs_n = 1'b0;
    @(negedge clk);
    s = stat;
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    cmd = 8'hFF;
    #1 check("R1 drive in reset", drv, 8'h00);
    check("R1 status in reset", stat, 8'h00);
    rst_n = 1'b1;
    #1 check("R1 drive before first edge", drv, 8'h00);
    @(negedge clk);
    #1 check("R1 drive after first edge", drv, 8'hFF);
  endtask

  task automatic t_drive;
    cmd = 8'hA5; #1 check("R2 pattern a5", drv, 8'hA5);
    step(1);
    cmd = 8'h5A; #1 check("R2 pattern 5a", drv, 8'h5A);
    step(1);
    cmd = 8'h00; #1 check("R2 all off", drv, 8'h00);
    step(1);
  endtask

  task automatic t_trip;
    cmd = 8'hFF;
    step(1);
    ovc = 6'b000100; // channel bit 4
    #1 check("R3 same-cycle off", drv, 8'hEF);
    step(1);
    ovc = '0;
    #1 check("R3 stays latched", drv, 8'hEF);
    upd = 1'b1;
    step(1);
    upd = 1'b0;
    #1 check("R5 update with on keeps latch", drv, 8'hEF);
    cmd = 8'hEF; upd = 1'b1;
    step(1);
    upd = 1'b0; cmd = 8'hFF;
    #1 check("R5 update with off clears latch", drv, 8'hFF);
    step(1);
  endtask

  task automatic t_thermal;
    ovt = 2'b01;
    #1 check("R4 same-cycle thermal off", drv, 8'hFE);
    step(1);
    ovt = '0;
    #1 check("R4 thermal latch holds", drv, 8'hFE);
    cmd = 8'hFE; upd = 1'b1;
    step(1);
    upd = 1'b0; cmd = 8'hFF;
    #1 check("R5 thermal latch cleared", drv, 8'hFF);
    step(1);
  endtask

  task automatic t_ch38;
    logic [7:0] s;
    cmd = 8'h3D; above = 8'hF2;
    step(1);
    rd(s);
    check("R6 live status", s & 8'hFC, 8'hCC);
    ovc = 6'b000100;
    step(1);
    ovc = '0;
    step(1);
    rd(s);
    check("R6 latched reads high", s & 8'hFC, 8'hDC);
    above = 8'h02;
    step(1);
    check("R9 hold while deselected", stat & 8'hFC, 8'hDC);
    cmd = 8'h2D; upd = 1'b1;
    step(1);
    upd = 1'b0;
  endtask

  task automatic t_filter;
    logic [7:0] s;
    cmd = 8'h01; above = 8'h02;
    step(2);
    rd(s); rd(s);
    check("R7 no fault", s & 8'h03, 8'h03);
    above[0] = 1'b1; step(F-1); above[0] = 1'b0;
    step(1); rd(s);
    check("R7 short condition ignored", s & 8'h03, 8'h03);
    above[0] = 1'b1; step(F-1); above[0] = 1'b0; step(1);
    above[0] = 1'b1; step(F-1); above[0] = 1'b0;
    step(1); rd(s);
    check("R8 count restarts", s & 8'h03, 8'h03);
    above[0] = 1'b1; step(F); above[0] = 1'b0;
    step(2); rd(s);
    check("R7 type1 latched", s & 8'h03, 8'h02);
    rd(s);
    check("R9 gone fault clears", s & 8'h03, 8'h03);
    above[1] = 1'b0; step(F); above[1] = 1'b1;
    step(1); rd(s);
    check("R7 type2 latched", s & 8'h03, 8'h01);
    cs_n = 1'b0; above[0] = 1'b1;
    step(F+4);
    cs_n = 1'b1; above[0] = 1'b0;
    step(2); rd(s);
    check("R10 masked while selected", s & 8'h03, 8'h03);
    above[0] = 1'b1; step(F+1);
    rd(s);
    check("R9 persistent first read", s & 8'h03, 8'h02);
    rd(s);
    check("R9 persistent second read", s & 8'h03, 8'h02);
    above[0] = 1'b0;
    step(1);
  endtask

  initial begin
    step(3);
    t_reset();
    t_drive();
    t_trip();
    t_thermal();
    t_ch38();
    t_filter();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule